// File: doc/BRIEF.md
# Strobe/Acknowledge Link Protocol Monitor

This block watches one point-to-point link on which a sender offers a payload together with a strobe and a receiver answers with an acknowledge. It only listens. It never drives a link signal. On every rising clock edge it samples the payload, the strobe, the acknowledge and a sender-side "payload waiting" hint, and it judges what it sees against the handshake rules. Any rule that is broken sets its own sticky flag. The same edge also produces a one-cycle mask of the rules that failed and a single error pulse.

Besides the rule checks, the monitor counts completed transfers and pulses a transfer-seen output for each one. A configurable stall limit raises a warning when only one of the two handshake signals has been high for too long. A limit of zero turns this warning off. The block is meant to be bound beside any link that follows this convention, both in simulation and on silicon for debug.

All outputs are registered. A condition sampled at edge k is visible on the outputs just after edge k.

Top module: `hs_link_monitor`

## Requirements
- R1: A rising edge with `rst` high clears `err_sticky`, `err_now`, `err_pulse`, `xfer_count`, `xfer_seen` and `stall_warn` to zero. It also discards any open transaction.
- R2: At the first edge with `rst` low after a reset edge, a high strobe or a high acknowledge sets mask bit 0 (reset rule).
- R3: If the strobe was high without the acknowledge at one edge and is low at the next edge, mask bit 1 is set (strobe dropped).
- R4: If the strobe was high without the acknowledge at one edge and is still high at the next edge with a different payload, mask bit 2 is set. Payload changes while the strobe is low are never flagged.
- R5: If the acknowledge was high without the strobe at one edge and is low at the next edge, mask bit 3 is set (acknowledge dropped).
- R6: Each edge with both strobe and acknowledge high is one completed transfer. `xfer_count` rises by one (wrapping at its width) and `xfer_seen` is high for exactly the following cycle.
- R7: Strobe and acknowledge held high over consecutive edges count as one transfer per edge. A new payload at each such edge is legal.
- R8: An edge with `tx_pending` high while both strobe and acknowledge are low sets mask bit 4 (strobe withheld). With the acknowledge high, a pending sender holding its strobe low is not flagged.
- R9: `err_now` holds the mask of the rules broken at the last edge. `err_pulse` is high when that mask is non-zero. `err_sticky` accumulates every mask bit until the next reset edge.
- R10: `stall_warn` is high after an edge at which exactly one of strobe and acknowledge has been high for more than `STALL_LIMIT` consecutive edges. It clears at the first edge where that no longer holds. With `STALL_LIMIT` = 0 it stays low.
- R11: Legal traffic raises no flag. Legal traffic includes receiver wait states (strobe held until the acknowledge comes) and sender wait states (acknowledge held until the strobe comes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| link_data | input | DATA_W | Payload observed on the link |
| link_stb | input | 1 | Sender strobe: payload valid |
| link_ack | input | 1 | Receiver acknowledge: ready to take payload |
| tx_pending | input | 1 | Sender hint that a payload is waiting to go out |
| err_sticky | output | 5 | Accumulated rule-failure flags, cleared by reset |
| err_now | output | 5 | Rules broken at the most recent edge |
| err_pulse | output | 1 | One-cycle pulse when any rule broke at the last edge |
| xfer_count | output | CNT_W | Completed transfer count, wrapping |
| xfer_seen | output | 1 | One-cycle pulse per completed transfer |
| stall_warn | output | 1 | One handshake side has waited beyond the stall limit |

## Verification
An open-transaction bit that is wrong inside the monitor shows up as a spurious or missing strobe-drop, acknowledge-drop or payload-change bit in `err_now`. This appears on the very next edge at which the link moves. A held payload copy that is wrong gives a false payload-change bit on the first repeated strobe cycle. Counter or stall-timer faults are visible at once in `xfer_count` or `stall_warn`. The bench therefore compares every output against an independent model after each edge, under both directed sequences and long random runs with occasional resets.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;

    // Number of protocol rules judged by the monitor.
    localparam int RULE_N = 5;

    // Bit positions of each rule inside the failure masks.
    localparam int BIT_RST      = 0;
    localparam int BIT_STB_DROP = 1;
    localparam int BIT_DATA_CHG = 2;
    localparam int BIT_ACK_DROP = 3;
    localparam int BIT_STB_HOLD = 4;

    typedef logic [RULE_N-1:0] rule_mask_t;

endpackage

// File: rtl/hs_rule_check.sv
module hs_rule_check
    import hs_mon_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data,
    input  logic              stb,
    input  logic              ack,
    input  logic              pend,
    output rule_mask_t        viol,
    output logic              done
);

    // Tracking state carried from one edge to the next.
    typedef struct packed {
        logic              after_rst;
        logic              stb_open;
        logic              ack_open;
        logic [DATA_W-1:0] held;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        viol  = '0;
        done  = 1'b0;
        if (rst) begin
            trk_d           = '0;
            trk_d.after_rst = 1'b1;
        end else begin
            done = stb & ack;

            viol[BIT_RST]      = trk_q.after_rst & (stb | ack);
            viol[BIT_STB_DROP] = trk_q.stb_open & ~stb;
            viol[BIT_DATA_CHG] = trk_q.stb_open & stb & (data != trk_q.held);
            viol[BIT_ACK_DROP] = trk_q.ack_open & ~ack;
            viol[BIT_STB_HOLD] = pend & ~stb & ~ack;

            // A side stays committed only while the other has not matched it.
            trk_d.after_rst = 1'b0;
            trk_d.stb_open  = stb & ~ack;
            trk_d.ack_open  = ack & ~stb;
            if (stb) begin
                trk_d.held = data;
            end
        end
    end

    always_ff @(posedge clk) begin
        trk_q <= trk_d;
    end

    // A waiting strobe that vanishes must be reported on that edge.
    p_stb_drop_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(stb && !ack) && !stb) |-> viol[BIT_STB_DROP]);

    // A waiting strobe with a new payload must be reported.
    p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(stb && !ack) && stb && (data != $past(data)))
            |-> viol[BIT_DATA_CHG]);

    // A waiting acknowledge that vanishes must be reported.
    p_ack_drop_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(ack && !stb) && !ack) |-> viol[BIT_ACK_DROP]);

endmodule

// File: rtl/hs_stall_timer.sv
module hs_stall_timer #(
    parameter int STALL_LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic ack,
    output logic warn
);

    generate
        if (STALL_LIMIT == 0) begin : g_off
            assign warn = 1'b0;
        end else begin : g_on
            localparam int CW = $clog2(STALL_LIMIT + 2);
            localparam logic [CW-1:0] SAT = CW'(STALL_LIMIT + 1);
            localparam logic [CW-1:0] LIM = CW'(STALL_LIMIT);

            typedef struct packed {
                logic [CW-1:0] cnt;
                logic          warn;
            } stall_t;

            stall_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (rst) begin
                    st_d = '0;
                end else begin
                    if (stb ^ ack) begin
                        // Saturate just past the limit; that is all the warning needs.
                        if (st_q.cnt != SAT) begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end else begin
                        st_d.cnt = '0;
                    end
                    st_d.warn = (st_d.cnt > LIM);
                end
            end

            always_ff @(posedge clk) begin
                st_q <= st_d;
            end

            assign warn = st_q.warn;

            // A warning can only follow an edge where one side stood alone.
            p_warn_cause_r10: assert property (@(posedge clk) disable iff (rst)
                warn |-> $past(stb ^ ack));
        end
    endgenerate

endmodule

// File: rtl/hs_xfer_tally.sv
module hs_xfer_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    output logic [CNT_W-1:0] count,
    output logic             seen
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             seen;
    } tally_t;

    tally_t ty_d, ty_q;

    always_comb begin
        ty_d = ty_q;
        if (rst) begin
            ty_d = '0;
        end else begin
            ty_d.seen = done;
            if (done) begin
                ty_d.count = ty_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        ty_q <= ty_d;
    end

    assign count = ty_q.count;
    assign seen  = ty_q.seen;

    // The count advances by exactly the completions reported by the rule logic.
    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count == $past(count) + CNT_W'($past(done))));

endmodule

// File: rtl/hs_link_monitor.sv
module hs_link_monitor
    import hs_mon_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 16,
    parameter int STALL_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] link_data,
    input  logic              link_stb,
    input  logic              link_ack,
    input  logic              tx_pending,
    output logic [RULE_N-1:0] err_sticky,
    output logic [RULE_N-1:0] err_now,
    output logic              err_pulse,
    output logic [CNT_W-1:0]  xfer_count,
    output logic              xfer_seen,
    output logic              stall_warn
);

    rule_mask_t viol;
    logic       done;

    hs_rule_check #(
        .DATA_W (DATA_W)
    ) u_rules (
        .clk  (clk),
        .rst  (rst),
        .data (link_data),
        .stb  (link_stb),
        .ack  (link_ack),
        .pend (tx_pending),
        .viol (viol),
        .done (done)
    );

    hs_xfer_tally #(
        .CNT_W (CNT_W)
    ) u_tally (
        .clk   (clk),
        .rst   (rst),
        .done  (done),
        .count (xfer_count),
        .seen  (xfer_seen)
    );

    hs_stall_timer #(
        .STALL_LIMIT (STALL_LIMIT)
    ) u_stall (
        .clk  (clk),
        .rst  (rst),
        .stb  (link_stb),
        .ack  (link_ack),
        .warn (stall_warn)
    );

    // Failure reporting registers.
    typedef struct packed {
        rule_mask_t sticky;
        rule_mask_t now;
        logic       pulse;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (rst) begin
            fl_d = '0;
        end else begin
            fl_d.now    = viol;
            fl_d.pulse  = |viol;
            fl_d.sticky = fl_q.sticky | viol;
        end
    end

    always_ff @(posedge clk) begin
        fl_q <= fl_d;
    end

    assign err_sticky = fl_q.sticky;
    assign err_now    = fl_q.now;
    assign err_pulse  = fl_q.pulse;

    // Flags already raised stay raised until reset.
    p_sticky_keep_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

    // Every fresh failure is also recorded in the sticky flags.
    p_now_in_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (err_now & ~err_sticky) == '0);

    // A transfer pulse always comes with a count that has just moved.
    p_seen_counts_r6: assert property (@(posedge clk) disable iff (rst)
        xfer_seen |-> (xfer_count == $past(xfer_count) + 1'b1));

endmodule

// File: tb/hs_link_monitor_bench.sv
`timescale 1ns/1ps
module hs_link_monitor_bench;

    localparam int DW  = 8;
    localparam int CW  = 8;
    localparam int LIM = 4;

    logic          clk  = 1'b0;
    logic          rst  = 1'b1;
    logic [DW-1:0] data = '0;
    logic          stb  = 1'b0;
    logic          ack  = 1'b0;
    logic          pend = 1'b0;

    logic [4:0]    err_sticky, err_now;
    logic          err_pulse, xfer_seen, stall_warn;
    logic [CW-1:0] xfer_count;

    logic [4:0]    n_sticky, n_now;
    logic          n_pulse, n_seen, n_warn;
    logic [CW-1:0] n_count;

    always #5 clk = ~clk;

    hs_link_monitor #(.DATA_W(DW), .CNT_W(CW), .STALL_LIMIT(LIM)) u_hs_link_monitor (
        .clk(clk), .rst(rst), .link_data(data), .link_stb(stb), .link_ack(ack),
        .tx_pending(pend), .err_sticky(err_sticky), .err_now(err_now),
        .err_pulse(err_pulse), .xfer_count(xfer_count), .xfer_seen(xfer_seen),
        .stall_warn(stall_warn)
    );

    // Second copy with the stall warning disabled.
    hs_link_monitor #(.DATA_W(DW), .CNT_W(CW), .STALL_LIMIT(0)) u_hs_link_monitor_nolim (
        .clk(clk), .rst(rst), .link_data(data), .link_stb(stb), .link_ack(ack),
        .tx_pending(pend), .err_sticky(n_sticky), .err_now(n_now),
        .err_pulse(n_pulse), .xfer_count(n_count), .xfer_seen(n_seen),
        .stall_warn(n_warn)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Reference model state, built from the requirements.
    bit          m_after, m_open_s, m_open_a, m_seen, m_warn;
    logic [DW-1:0] m_held;
    logic [4:0]  m_now, m_sticky;
    int          m_count, m_stall;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] rule_mask(input bit s, a, p, input logic [DW-1:0] d);
        logic [4:0] m = '0;
        m[0] = m_after && (s || a);
        m[1] = m_open_s && !s;
        m[2] = m_open_s && s && (d != m_held);
        m[3] = m_open_a && !a;
        m[4] = p && !s && !a;
        return m;
    endfunction

    task automatic model_edge(input bit r, s, a, input logic [DW-1:0] d, input bit p);
        if (r) begin
            m_after = 1; m_open_s = 0; m_open_a = 0; m_seen = 0; m_warn = 0;
            m_now = '0; m_sticky = '0; m_count = 0; m_stall = 0;
        end else begin
            m_now    = rule_mask(s, a, p, d);
            m_sticky = m_sticky | m_now;
            m_seen   = s && a;
            if (s && a) m_count = (m_count + 1) % (1 << CW);
            m_after  = 0;
            m_open_s = s && !a;
            m_open_a = a && !s;
            if (s) m_held = d;
            if (s != a) m_stall++; else m_stall = 0;
            m_warn   = (m_stall > LIM);
        end
    endtask

    task automatic step(input bit r, s, a, input logic [DW-1:0] d, input bit p);
        @(negedge clk);
        rst = r; stb = s; ack = a; data = d; pend = p;
        @(posedge clk);
        #1;
        model_edge(r, s, a, d, p);
        chk("R9 err_now", 32'(err_now), 32'(m_now));
        chk("R9 err_sticky", 32'(err_sticky), 32'(m_sticky));
        chk("R9 err_pulse", 32'(err_pulse), 32'(m_now != 0));
        chk("R6 xfer_count", 32'(xfer_count), 32'(m_count));
        chk("R6 xfer_seen", 32'(xfer_seen), 32'(m_seen));
        chk("R10 stall_warn", 32'(stall_warn), 32'(m_warn));
        chk("R10 disabled warn", 32'(n_warn), 32'd0);
    endtask

    task automatic do_reset(input bit idle_after);
        step(1, 0, 0, '0, 0);
        step(1, 0, 0, '0, 0);
        if (idle_after) step(0, 0, 0, '0, 0);
    endtask

    initial begin
        #(10 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit rs, ra;
        logic [DW-1:0] rd;
        void'($urandom(32'h5EED_0042));

        // R1: reset state
        do_reset(0);
        chk("R1 sticky after reset", 32'(err_sticky), 0);
        chk("R1 count after reset", 32'(xfer_count), 0);
        chk("R1 warn after reset", 32'(stall_warn), 0);
        step(0, 0, 0, '0, 0);

        // R11: receiver wait states
        step(0, 1, 0, 8'hA5, 1);
        step(0, 1, 0, 8'hA5, 1);
        step(0, 1, 1, 8'hA5, 1);
        chk("R6 count after one transfer", 32'(xfer_count), 1);
        chk("R6 seen after transfer", 32'(xfer_seen), 1);
        chk("R11 legal receiver waits", 32'(err_sticky), 0);
        step(0, 0, 0, 8'h00, 0);
        chk("R6 seen lasts one cycle", 32'(xfer_seen), 0);

        // R11 and R4: sender waits, payload free while strobe is low
        step(0, 0, 1, 8'h11, 0);
        step(0, 0, 1, 8'h22, 0);
        step(0, 1, 1, 8'h33, 0);
        chk("R4 payload free with strobe low", 32'(err_sticky), 0);
        chk("R11 count after sender waits", 32'(xfer_count), 2);

        // R7: back-to-back transfers with new payload each edge
        step(0, 1, 1, 8'h01, 0);
        step(0, 1, 1, 8'h02, 0);
        step(0, 1, 1, 8'h03, 0);
        chk("R7 back-to-back count", 32'(xfer_count), 5);
        chk("R7 back-to-back no flag", 32'(err_sticky), 0);
        step(0, 0, 0, 8'h00, 0);

        // R2: strobe high on first edge out of reset
        do_reset(0);
        step(0, 1, 0, 8'hAA, 0);
        chk("R2 reset rule mask", 32'(err_now), 32'b00001);
        step(0, 1, 1, 8'hAA, 0);
        chk("R9 sticky holds reset rule", 32'(err_sticky), 32'b00001);

        // R3: strobe dropped before completion
        do_reset(1);
        step(0, 1, 0, 8'h05, 0);
        step(0, 0, 0, 8'h05, 0);
        chk("R3 strobe drop mask", 32'(err_now), 32'b00010);
        step(0, 0, 0, 8'h05, 0);
        chk("R9 now clears", 32'(err_now), 0);
        chk("R9 pulse clears", 32'(err_pulse), 0);
        chk("R9 sticky keeps drop", 32'(err_sticky), 32'b00010);

        // R4: payload changes under a waiting strobe
        do_reset(1);
        step(0, 1, 0, 8'h05, 0);
        step(0, 1, 0, 8'h06, 0);
        chk("R4 payload change mask", 32'(err_now), 32'b00100);
        step(0, 1, 1, 8'h06, 0);

        // R5: acknowledge dropped before completion
        do_reset(1);
        step(0, 0, 1, 8'h00, 0);
        step(0, 0, 0, 8'h00, 0);
        chk("R5 ack drop mask", 32'(err_now), 32'b01000);

        // R8: strobe withheld while payload waits
        do_reset(1);
        step(0, 0, 0, 8'h00, 1);
        chk("R8 withheld strobe mask", 32'(err_now), 32'b10000);
        do_reset(1);
        step(0, 0, 1, 8'h00, 1);
        chk("R8 pending with ack high allowed", 32'(err_now), 0);
        step(0, 1, 1, 8'h00, 0);

        // R10: stall warning at limit and just past it
        do_reset(1);
        for (int i = 0; i < LIM; i++) step(0, 1, 0, 8'h7E, 0);
        chk("R10 no warn at limit", 32'(stall_warn), 0);
        step(0, 1, 0, 8'h7E, 0);
        chk("R10 warn past limit", 32'(stall_warn), 1);
        chk("R10 zero limit stays quiet", 32'(n_warn), 0);
        step(0, 1, 1, 8'h7E, 0);
        chk("R10 warn clears on completion", 32'(stall_warn), 0);

        // Random traffic mixing legal and illegal behaviour
        do_reset(1);
        rs = 0; ra = 0; rd = '0;
        for (int i = 0; i < 4000; i++) begin
            bit r, p;
            r = ($urandom % 80) == 0;
            if (rs && !ra) rs = ($urandom % 12) != 0; else rs = ($urandom % 2) == 1;
            if (ra && !rs) ra = ($urandom % 12) != 0; else ra = ($urandom % 2) == 1;
            if (($urandom % 6) == 0) rd = DW'($urandom);
            p = ($urandom % 5) == 0;
            step(r, rs, ra, rd, p);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule